// File: doc/BRIEF.md
# Masked BCD Repeating Alarm

This block holds four alarm bytes (seconds, minutes, hours and day of month) in packed BCD and compares them against the time-of-day fields that an external timekeeper presents. The comparison runs once per second, on a one-cycle tick. When the compared fields agree, the block emits a single-cycle interrupt pulse. The timekeeper itself lies outside the block.

The top bit of every alarm byte is a "don't care" flag. The pattern of these flags across the four bytes sets how often the alarm repeats. Clearing all flags gives a monthly alarm. The other patterns give a daily, hourly, per-minute or per-second alarm. Software programs the bytes through a byte-wide port with a two-bit register index. A write whose BCD value lies outside the field's legal range is dropped, and the old contents stay in place.

Top module: `alarm_match_top`

## Requirements
- R1: Register index 0 selects seconds, 1 minutes, 2 hours and 3 day of month; `rdData` always shows the stored byte of the register that `regAddr` selects.
- R2: A seconds or minutes write is stored only when bits 6:0 form valid BCD with a low digit of 9 or less and a value of 0x59 or less; otherwise the register is unchanged.
- R3: An hours write is stored only when bits 5:0 form valid BCD with a value of 0x23 or less; otherwise the register is unchanged.
- R4: A day-of-month write is stored only when bits 5:0 are nonzero; otherwise the register is unchanged.
- R5: An accepted write stores all eight bits, including bit 7, and the stored byte reads back unchanged.
- R6: With bit 7 clear in all four registers, a tick raises the interrupt only when date (bits 5:0), hours (bits 5:0), minutes (bits 6:0) and seconds (bits 6:0) all equal the time inputs.
- R7: With bit 7 set only in the date register, a tick raises the interrupt when hours, minutes and seconds match, whatever the date.
- R8: With bit 7 set in date and hours only, a tick raises the interrupt when minutes and seconds match.
- R9: With bit 7 set in date, hours and minutes only, a tick raises the interrupt when seconds match.
- R10: Any other mask pattern raises the interrupt on every tick.
- R11: `alarmIrq` is high for exactly the one cycle after the clock edge that samples a matching tick, and never follows a cycle without a tick.
- R12: Reset clears all four registers and the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the selected register |
| regAddr | input | 2 | Register index for write and read |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Stored byte of the selected register |
| secTick | input | 1 | One-cycle pulse, once per second |
| timeSec | input | 8 | Current seconds, BCD |
| timeMin | input | 8 | Current minutes, BCD |
| timeHour | input | 8 | Current hours, BCD |
| timeDate | input | 8 | Current day of month, BCD |
| alarmIrq | output | 1 | Alarm interrupt pulse |

## Verification
The assertions assume that `secTick` never stays high on two cycles in a row. Without that, back-to-back matches would stretch the pulse past one cycle. The bench always leaves at least one idle cycle between ticks, and it changes the time fields only while the tick is low. The assertions also assume that the time inputs already hold legal BCD. The bench draws every time value from legal BCD. Only the alarm writes sweep the full byte range.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int DATA_W     = 8;
  localparam int NUM_FIELDS = 4;
  localparam int ADDR_W     = $clog2(NUM_FIELDS);

  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_DATE = 3;

  typedef struct packed {
    logic [NUM_FIELDS-1:0] load;   // store wrData into field i
    logic [NUM_FIELDS-1:0] cmpEn;  // field i takes part in the match
  } alarmStrobe_t;
endpackage

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import alarm_pkg::*;
(
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [NUM_FIELDS-1:0] maskBits,
  output alarmStrobe_t          strobe
);
  logic secMinOk, hourOk, dateOk;
  logic [NUM_FIELDS-1:0] fieldOk;

  // seconds/minutes: two BCD digits, tens 0..5, units 0..9
  assign secMinOk = (wrData[3:0] <= 4'd9) && (wrData[6:4] <= 3'd5);
  // hours: tens 0..1 with units 0..9, or tens 2 with units 0..3
  assign hourOk   = (wrData[3:0] <= 4'd9) &&
                    ((wrData[5:4] < 2'd2) || ((wrData[5:4] == 2'd2) && (wrData[3:0] <= 4'd3)));
  assign dateOk   = (wrData[5:0] != '0);

  always_comb begin
    fieldOk           = '0;
    fieldOk[IDX_SEC]  = secMinOk;
    fieldOk[IDX_MIN]  = secMinOk;
    fieldOk[IDX_HOUR] = hourOk;
    fieldOk[IDX_DATE] = dateOk;
  end

  genvar i;
  generate
    for (i = 0; i < NUM_FIELDS; i++) begin : g_load
      assign strobe.load[i] = wrEn && (wrAddr == ADDR_W'(i)) && fieldOk[i];
    end
  endgenerate

  // Repeat rate from the mask pattern {date,hour,min,sec}
  always_comb begin
    unique case (maskBits)
      4'b0000: strobe.cmpEn = 4'b1111; // monthly
      4'b1000: strobe.cmpEn = 4'b0111; // daily
      4'b1100: strobe.cmpEn = 4'b0011; // hourly
      4'b1110: strobe.cmpEn = 4'b0001; // each minute
      default: strobe.cmpEn = 4'b0000; // each second
    endcase
  end
endmodule

// File: rtl/alarm_dp.sv
module alarm_dp
  import alarm_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  alarmStrobe_t                       strobe,
  input  logic [DATA_W-1:0]                  wrData,
  input  logic                               secTick,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0]  timeNow,
  output logic [NUM_FIELDS-1:0][DATA_W-1:0]  regFile,
  output logic [NUM_FIELDS-1:0]              maskBits,
  output logic                               alarmIrq
);
  logic [NUM_FIELDS-1:0] fieldEq;
  logic                  hit;

  genvar i;
  generate
    for (i = 0; i < NUM_FIELDS; i++) begin : g_field
      localparam int CMP_W = (i == IDX_SEC || i == IDX_MIN) ? 7 : 6;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               regFile[i] <= '0;
        else if (strobe.load[i]) regFile[i] <= wrData;
      end

      assign maskBits[i] = regFile[i][DATA_W-1];
      assign fieldEq[i]  = (regFile[i][CMP_W-1:0] == timeNow[i][CMP_W-1:0]);
    end
  endgenerate

  assign hit = &(fieldEq | ~strobe.cmpEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) alarmIrq <= 1'b0;
    else       alarmIrq <= secTick && hit;
  end
endmodule

// File: rtl/alarm_match_top.sv
module alarm_match_top
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        regAddr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic              secTick,
  input  logic [7:0]        timeSec,
  input  logic [7:0]        timeMin,
  input  logic [7:0]        timeHour,
  input  logic [7:0]        timeDate,
  output logic              alarmIrq
);
  alarmStrobe_t                      strobe;
  logic [NUM_FIELDS-1:0]             maskBits;
  logic [NUM_FIELDS-1:0][DATA_W-1:0] regFile;
  logic [NUM_FIELDS-1:0][DATA_W-1:0] timeNow;

  assign timeNow = {timeDate, timeHour, timeMin, timeSec};

  alarm_ctrl u_ctrl (
    .wrEn     (wrEn),
    .wrAddr   (regAddr),
    .wrData   (wrData),
    .maskBits (maskBits),
    .strobe   (strobe)
  );

  alarm_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .secTick  (secTick),
    .timeNow  (timeNow),
    .regFile  (regFile),
    .maskBits (maskBits),
    .alarmIrq (alarmIrq)
  );

  assign rdData = regFile[regAddr];
endmodule

// File: rtl/alarm_match_checker.sv
module alarm_match_checker (
  input logic            clk,
  input logic            rstN,
  input logic            wrEn,
  input logic [1:0]      regAddr,
  input logic [7:0]      wrData,
  input logic            secTick,
  input logic            alarmIrq,
  input logic [3:0][7:0] regFile
);
  function automatic logic legal(input logic [1:0] a, input logic [7:0] v);
    int tens, units;
    tens  = (a == 2'd2 || a == 2'd3) ? int'(v[5:4]) : int'(v[6:4]);
    units = int'(v[3:0]);
    case (a)
      2'd0, 2'd1: return (units < 10) && (tens * 10 + units < 60);
      2'd2:       return (units < 10) && (tens * 10 + units < 24);
      default:    return v[5:0] != 6'd0;
    endcase
  endfunction

  logic [3:0] maskNow;
  assign maskNow = {regFile[3][7], regFile[2][7], regFile[1][7], regFile[0][7]};

  assert_irq_needs_tick_R11: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq |-> $past(secTick));

  assert_irq_single_cycle_R11: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq |=> !alarmIrq);

  assert_bad_write_kept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !legal(regAddr, wrData)) |=> $stable(regFile));

  assert_good_write_stored_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && legal(regAddr, wrData)) |=> (regFile[$past(regAddr)] == $past(wrData)));

  assert_every_second_R10: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && !(maskNow inside {4'b0000, 4'b1000, 4'b1100, 4'b1110})) |=> alarmIrq);
endmodule

bind alarm_match_top alarm_match_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .regAddr  (regAddr),
  .wrData   (wrData),
  .secTick  (secTick),
  .alarmIrq (alarmIrq),
  .regFile  (regFile)
);

// File: tb/alarm_match_top_bench.sv
module alarm_match_top_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       secTick = 1'b0;
  logic [7:0] timeSec = '0, timeMin = '0, timeHour = '0, timeDate = '0;
  logic       alarmIrq;

  int  nChecks = 0;
  int  nFails = 0;
  bit  done = 1'b0;
  logic [7:0] model [4];

  always #10 clk = ~clk; // 50 MHz

  alarm_match_top u_alarm_match_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .secTick(secTick), .timeSec(timeSec), .timeMin(timeMin),
    .timeHour(timeHour), .timeDate(timeDate), .alarmIrq(alarmIrq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit accepts(input int a, input int v);
    int lo = v % 16;
    case (a)
      0, 1: return (lo < 10) && (((v % 128) / 16) * 10 + lo <= 59);
      2:    return (lo < 10) && (((v % 64) / 16) * 10 + lo <= 23);
      default: return (v % 64) != 0;
    endcase
  endfunction

  // write at a negedge, result visible on rdData at the next negedge
  task automatic writeReg(input int a, input int v);
    @(negedge clk);
    wrEn = 1'b1; regAddr = 2'(a); wrData = 8'(v);
    @(negedge clk);
    wrEn = 1'b0;
    if (accepts(a, v)) model[a] = 8'(v);
    check((accepts(a, v) ? "R5 store" : (a < 2 ? "R2 reject" : (a == 2 ? "R3 reject" : "R4 reject"))),
          rdData, model[a]);
  endtask

  function automatic bit expectHit(input logic [7:0] s, input logic [7:0] m,
                                   input logic [7:0] h, input logic [7:0] d);
    bit eqS = (model[0] % 128) == (s % 128);
    bit eqM = (model[1] % 128) == (m % 128);
    bit eqH = (model[2] % 64) == (h % 64);
    bit eqD = (model[3] % 64) == (d % 64);
    int pat = (model[3] >= 128) * 8 + (model[2] >= 128) * 4 + (model[1] >= 128) * 2 + (model[0] >= 128);
    case (pat)
      0:  return eqD && eqH && eqM && eqS;
      8:  return eqH && eqM && eqS;
      12: return eqM && eqS;
      14: return eqS;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string modeReq();
    int pat = (model[3] >= 128) * 8 + (model[2] >= 128) * 4 + (model[1] >= 128) * 2 + (model[0] >= 128);
    case (pat)
      0: return "R6 monthly";  8: return "R7 daily";  12: return "R8 hourly";
      14: return "R9 minute";  default: return "R10 every-second";
    endcase
  endfunction

  task automatic tickCheck(input logic [7:0] s, input logic [7:0] m,
                           input logic [7:0] h, input logic [7:0] d);
    @(negedge clk);
    timeSec = s; timeMin = m; timeHour = h; timeDate = d;
    @(negedge clk);
    check("R11 no tick no pulse", {7'd0, alarmIrq}, 8'd0);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
    check(modeReq(), {7'd0, alarmIrq}, {7'd0, expectHit(s, m, h, d)});
    @(negedge clk);
    check("R11 pulse width", {7'd0, alarmIrq}, 8'd0);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R12 reset state, R1 index map
    for (int a = 0; a < 4; a++) begin
      @(negedge clk); regAddr = 2'(a);
      #1 check("R12 reset reg", rdData, 8'h00);
    end
    check("R12 reset irq", {7'd0, alarmIrq}, 8'd0);

    // R1 distinct values per index
    writeReg(0, 8'h11); writeReg(1, 8'h22); writeReg(2, 8'h13); writeReg(3, 8'h24);
    for (int a = 0; a < 4; a++) begin
      @(negedge clk); regAddr = 2'(a);
      #1 check("R1 index map", rdData, model[a]);
    end

    // R2 R3 R4 R5 exhaustive write sweep
    for (int a = 0; a < 4; a++)
      for (int v = 0; v < 256; v++)
        writeReg(a, v);

    // R6..R10 all mask patterns against five time vectors
    for (int pat = 0; pat < 16; pat++) begin
      writeReg(0, (pat & 1) ? 8'hB0 : 8'h30);
      writeReg(1, (pat & 2) ? 8'h95 : 8'h15);
      writeReg(2, (pat & 4) ? 8'h92 : 8'h12);
      writeReg(3, (pat & 8) ? 8'h87 : 8'h07);
      tickCheck(8'h30, 8'h15, 8'h12, 8'h07);
      tickCheck(8'h30, 8'h15, 8'h12, 8'h08);
      tickCheck(8'h30, 8'h15, 8'h13, 8'h07);
      tickCheck(8'h30, 8'h16, 8'h12, 8'h07);
      tickCheck(8'h31, 8'h15, 8'h12, 8'h07);
    end

    // R12 reset mid-run clears stored bytes
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    for (int i = 0; i < 4; i++) model[i] = 8'h00;
    for (int a = 0; a < 4; a++) begin
      @(negedge clk); regAddr = 2'(a);
      #1 check("R12 reset clears", rdData, 8'h00);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule